// File: doc/BRIEF.md
# Shared Bus Emulator with Direction-Controlled Transceiver

This block stands in for shared tristate buses on a fabric that has no internal high-impedance wires. It models two 16-bit buses, one on the processor side and one on the memory side. Every attached agent hands the block a separate output word and an output-enable, and gets the resolved bus value back on a data-in port. No agent ever drives a floating value. On each bus a priority multiplexer, selected by the enables, picks the driving word. When nothing drives the bus, it reads as all ones, the way a pulled-up bus would.

A transceiver model joins the two buses. When it is enabled it copies one side onto the other, and a read/write line sets the direction. The transceiver counts as one more agent on each bus. It ranks below all of the bus's own agents. The value it forwards is resolved only from the other side's own agents, so the two multiplexers never feed each other in a loop. Each bus raises a contention flag in the same cycle whenever two or more drivers are enabled together. A clocked copy of the combined flags is also provided.

Top module: `shared_bus_emu`

## Requirements
- R1: When exactly one native agent on a bus has its enable high, that agent's output word appears on the bus data-in port in the same cycle. Agent k's word occupies bits [k*16 +: 16] of the bus's packed output-word port, and its enable is bit k of the enable port.
- R2: When several native agents on one bus are enabled together, the agent with the lowest index wins. The transceiver ranks after every native agent of that bus.
- R3: When no driver is enabled on a bus, its data-in port reads 16'hFFFF.
- R4: With the transceiver enabled and the read/write line low (write), the memory-side bus receives the processor-side value resolved from processor-side native agents only. If none of those is enabled, that value is 16'hFFFF.
- R5: With the transceiver enabled and the read/write line high (read), the processor-side bus receives the memory-side value resolved from memory-side native agents only.
- R6: With the transceiver disabled, neither bus has a transceiver driver. When it is enabled, it drives only the side selected by the read/write line and adds nothing to the other side.
- R7: A bus's contention output is high in the same cycle exactly when two or more of its drivers are enabled, the transceiver counted as a driver when it drives that bus.
- R8: The registered contention output equals the OR of both buses' contention outputs one clock earlier. It is 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the registered contention flag |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_dout_i | input | N_CPU*16 | Packed output words of processor-side agents |
| cpu_oe_i | input | N_CPU | Output-enables of processor-side agents |
| cpu_din_o | output | 16 | Resolved processor-side bus value |
| ram_dout_i | input | N_RAM*16 | Packed output words of memory-side agents |
| ram_oe_i | input | N_RAM | Output-enables of memory-side agents |
| ram_din_o | output | 16 | Resolved memory-side bus value |
| xcvr_en_i | input | 1 | Transceiver enable |
| xcvr_rd_i | input | 1 | Transceiver direction: 1 read (memory to processor), 0 write |
| cpu_clash_o | output | 1 | Processor-side contention, combinational |
| ram_clash_o | output | 1 | Memory-side contention, combinational |
| clash_q_o | output | 1 | Registered OR of both contention flags |

## Verification
Transceiver forwarding and native-agent resolution can act on the same bus in one cycle. In that cycle the priority order and the contention flag must both hold. The bench sweeps every combination of enables on both sides against the transceiver's enable and direction, so native drivers, the transceiver and idle buses all meet. Each data-in port is compared with a model that resolves the other side first and then ranks the transceiver last. The model also counts the drivers on each bus to judge the combinational and registered contention outputs.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
  localparam int unsigned BUS_W = 16;
  typedef logic [BUS_W-1:0] word_t;
  localparam word_t IDLE_WORD = '1;  // pull-up level
endpackage

// File: rtl/bus_resolve.sv
module bus_resolve #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_DRV  = 2
) (
  input  logic [N_DRV*DATA_W-1:0] dout_i,
  input  logic [N_DRV-1:0]        oe_i,
  output logic [DATA_W-1:0]       value_o,
  output logic                    any_o,
  output logic                    clash_o
);
  localparam int unsigned CNT_W = $clog2(N_DRV + 1);

  logic [CNT_W-1:0] cnt;

  // lowest index wins: scan from the top so low indices overwrite
  always_comb begin
    value_o = '1;
    for (int k = N_DRV - 1; k >= 0; k--) begin
      if (oe_i[k]) value_o = dout_i[k*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < N_DRV; k++) cnt = cnt + CNT_W'(oe_i[k]);
  end

  assign any_o   = |oe_i;
  assign clash_o = (cnt > CNT_W'(1));
endmodule

// File: rtl/xcvr_bridge.sv
module xcvr_bridge #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              en_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] cpu_side_i,
  input  logic [DATA_W-1:0] ram_side_i,
  output logic              to_cpu_oe_o,
  output logic [DATA_W-1:0] to_cpu_o,
  output logic              to_ram_oe_o,
  output logic [DATA_W-1:0] to_ram_o
);
  assign to_cpu_oe_o = en_i & rd_i;
  assign to_ram_oe_o = en_i & ~rd_i;
  assign to_cpu_o    = ram_side_i;
  assign to_ram_o    = cpu_side_i;
endmodule

// File: rtl/clash_reg.sv
module clash_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clash_i,
  output logic clash_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clash_q_o <= 1'b0;
    else         clash_q_o <= clash_i;
  end
endmodule

// File: rtl/shared_bus_emu.sv
module shared_bus_emu
  import shbus_pkg::*;
#(
  parameter int unsigned DATA_W = BUS_W,
  parameter int unsigned N_CPU  = 2,
  parameter int unsigned N_RAM  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_CPU*DATA_W-1:0] cpu_dout_i,
  input  logic [N_CPU-1:0]        cpu_oe_i,
  output logic [DATA_W-1:0]       cpu_din_o,
  input  logic [N_RAM*DATA_W-1:0] ram_dout_i,
  input  logic [N_RAM-1:0]        ram_oe_i,
  output logic [DATA_W-1:0]       ram_din_o,
  input  logic                    xcvr_en_i,
  input  logic                    xcvr_rd_i,
  output logic                    cpu_clash_o,
  output logic                    ram_clash_o,
  output logic                    clash_q_o
);
  localparam int unsigned CPU_ALL = N_CPU + 1;
  localparam int unsigned RAM_ALL = N_RAM + 1;

  logic [DATA_W-1:0] cpu_native, ram_native;
  logic              cpu_any, ram_any;
  logic              cpu_nat_clash, ram_nat_clash;
  logic              br_cpu_oe, br_ram_oe;
  logic [DATA_W-1:0] br_cpu_val, br_ram_val;
  logic              cpu_full_any, ram_full_any;

  // native-only resolution: source of what the transceiver forwards
  bus_resolve #(.DATA_W(DATA_W), .N_DRV(N_CPU)) u_cpu_nat (
    .dout_i(cpu_dout_i), .oe_i(cpu_oe_i), .value_o(cpu_native),
    .any_o(cpu_any), .clash_o(cpu_nat_clash)
  );

  bus_resolve #(.DATA_W(DATA_W), .N_DRV(N_RAM)) u_ram_nat (
    .dout_i(ram_dout_i), .oe_i(ram_oe_i), .value_o(ram_native),
    .any_o(ram_any), .clash_o(ram_nat_clash)
  );

  xcvr_bridge #(.DATA_W(DATA_W)) u_bridge (
    .en_i(xcvr_en_i), .rd_i(xcvr_rd_i),
    .cpu_side_i(cpu_native), .ram_side_i(ram_native),
    .to_cpu_oe_o(br_cpu_oe), .to_cpu_o(br_cpu_val),
    .to_ram_oe_o(br_ram_oe), .to_ram_o(br_ram_val)
  );

  // full buses: transceiver appended at the top index (lowest priority)
  bus_resolve #(.DATA_W(DATA_W), .N_DRV(CPU_ALL)) u_cpu_bus (
    .dout_i({br_cpu_val, cpu_dout_i}), .oe_i({br_cpu_oe, cpu_oe_i}),
    .value_o(cpu_din_o), .any_o(cpu_full_any), .clash_o(cpu_clash_o)
  );

  bus_resolve #(.DATA_W(DATA_W), .N_DRV(RAM_ALL)) u_ram_bus (
    .dout_i({br_ram_val, ram_dout_i}), .oe_i({br_ram_oe, ram_oe_i}),
    .value_o(ram_din_o), .any_o(ram_full_any), .clash_o(ram_clash_o)
  );

  clash_reg u_clash_reg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clash_i(cpu_clash_o | ram_clash_o), .clash_q_o(clash_q_o)
  );

  // R3: idle processor bus reads as pull-up
  a_r3_idle_pullup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_oe_i == '0 && !(xcvr_en_i && xcvr_rd_i)) |-> cpu_din_o == '1);

  // R4: write forwards processor agent 0 when memory side is idle
  a_r4_write_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xcvr_en_i && !xcvr_rd_i && cpu_oe_i[0] && ram_oe_i == '0)
      |-> ram_din_o == cpu_dout_i[DATA_W-1:0]);

  // R5: read forwards memory agent 0 when processor side is idle
  a_r5_read_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xcvr_en_i && xcvr_rd_i && ram_oe_i[0] && cpu_oe_i == '0)
      |-> cpu_din_o == ram_dout_i[DATA_W-1:0]);

  // R6: disabled transceiver leaves idle memory bus at pull-up
  a_r6_bridge_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xcvr_en_i && ram_oe_i == '0) |-> ram_din_o == '1);

  // R7: two native enables always flag contention
  a_r7_cpu_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(cpu_oe_i) >= 2) |-> cpu_clash_o);
  a_r7_ram_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(ram_oe_i) >= 2) |-> ram_clash_o);

  // R8: registered flag follows combined flags by one cycle
  a_r8_clash_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> clash_q_o == $past(cpu_clash_o | ram_clash_o));
endmodule

// File: tb/shared_bus_emu_tb.sv
`timescale 1ns/1ps
module shared_bus_emu_tb;
  localparam int W = 16;
  localparam int NC = 2;
  localparam int NR = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC*W-1:0] cpu_dout = '0;
  logic [NC-1:0]   cpu_oe = '0;
  logic [W-1:0]    cpu_din;
  logic [NR*W-1:0] ram_dout = '0;
  logic [NR-1:0]   ram_oe = '0;
  logic [W-1:0]    ram_din;
  logic            en = 1'b0, rd = 1'b0;
  logic            cpu_clash, ram_clash, clash_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shared_bus_emu #(.DATA_W(W), .N_CPU(NC), .N_RAM(NR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_dout_i(cpu_dout), .cpu_oe_i(cpu_oe), .cpu_din_o(cpu_din),
    .ram_dout_i(ram_dout), .ram_oe_i(ram_oe), .ram_din_o(ram_din),
    .xcvr_en_i(en), .xcvr_rd_i(rd),
    .cpu_clash_o(cpu_clash), .ram_clash_o(ram_clash), .clash_q_o(clash_q)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [W-1:0] pick(input logic [NC*W-1:0] d,
                                        input logic [NC-1:0] oe);
    for (int k = 0; k < NC; k++) if (oe[k]) return d[k*W +: W];
    return 16'hFFFF;
  endfunction

  function automatic int ones(input logic [NC-1:0] v);
    int c = 0;
    for (int k = 0; k < NC; k++) c += int'(v[k]);
    return c;
  endfunction

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] cn, rn, ce, re;
    logic         bw, br, cc, rc, prev_or;
    int           nc, nr;
    string        tag;
    // reset state
    repeat (2) @(posedge clk);
    #5;
    check("R8", "clash_q in reset", {15'b0, clash_q}, 16'h0);
    check("R3", "cpu idle", cpu_din, 16'hFFFF);
    check("R3", "ram idle", ram_din, 16'hFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    // two swept passes with different data patterns
    for (int pass = 0; pass < 2; pass++) begin
      for (int combo = 0; combo < 64; combo++) begin
        @(negedge clk);
        for (int k = 0; k < NC; k++)
          cpu_dout[k*W +: W] = 16'hC000 + 16'(combo * 4 + k) + 16'(pass * 16'h0100);
        for (int k = 0; k < NR; k++)
          ram_dout[k*W +: W] = 16'h5A00 ^ (16'(combo * 8 + k) << pass);
        cpu_oe = combo[1:0];
        ram_oe = combo[3:2];
        en     = combo[4];
        rd     = combo[5];
        #5;
        cn = pick(cpu_dout, cpu_oe);
        rn = pick(ram_dout, ram_oe);
        bw = en & ~rd;
        br = en & rd;
        nc = ones(cpu_oe);
        nr = ones(ram_oe);
        ce = (nc > 0) ? cn : (br ? rn : 16'hFFFF);
        re = (nr > 0) ? rn : (bw ? cn : 16'hFFFF);
        cc = (nc + int'(br)) >= 2;
        rc = (nr + int'(bw)) >= 2;

        if (nc >= 2)      tag = "R2";
        else if (nc == 1) tag = "R1";
        else if (br)      tag = "R5";
        else if (en)      tag = "R6";
        else              tag = "R3";
        check(tag, "cpu_din", cpu_din, ce);

        if (nr >= 2)      tag = "R2";
        else if (nr == 1) tag = "R1";
        else if (bw)      tag = "R4";
        else if (en)      tag = "R6";
        else              tag = "R3";
        check(tag, "ram_din", ram_din, re);

        check("R7", "cpu_clash", {15'b0, cpu_clash}, {15'b0, cc});
        check("R7", "ram_clash", {15'b0, ram_clash}, {15'b0, rc});
        prev_or = cc | rc;
        @(posedge clk);
        #1;
        check("R8", "clash_q", {15'b0, clash_q}, {15'b0, prev_or});
      end
    end
    // reset clears the registered flag while contention is held
    @(negedge clk);
    cpu_oe = 2'b11;
    @(posedge clk); #1;
    check("R8", "clash_q set", {15'b0, clash_q}, 16'h1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", "clash_q async clear", {15'b0, clash_q}, 16'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule